// File: doc/BRIEF.md
# Configurable Synchronous Shift-Out Engine

This block turns a short list of data fields into a serial stream on a data output and a clock output. It takes up to four fields, each 16 bits wide, with a separate bit count for each field. All fields are sent back to back as one continuous stream. A single order input picks whether each field goes out lowest bit first or highest bit first. Only the low bits of a field, up to its count, are ever sent. With a count of 4 and the value 250 in highest-first order, the line carries 1, 0, 1, 0.

The host places the field values, the width codes, a field count, the order and three phase lengths on the inputs, then pulses the start input. The engine captures all of these on that edge. It drops the clock low for one cycle and then presents each bit on the data output. Each bit is held for a setup phase with the clock low, then for a high phase, then for a hold phase with the clock low. A one-cycle done pulse marks the end of the transfer. The total low time between pulses is the hold phase plus the setup phase, so the low time is longer than the high phase whenever the phase settings are equal.

Top module: `sync_shift_tx`

## Requirements
- R1: A start pulse seen while `busy` is low captures every configuration input on that edge. `busy` then rises on the next cycle and stays high until the cycle in which `done` is asserted. A start pulse while `busy` is high has no effect on the stream, on its timing or on what follows.
- R2: `sclk` is low whenever the engine is idle. The first cycle after an accepted start keeps `sclk` low and leaves `sdo` unchanged. The first data bit appears one cycle later.
- R3: `sdo` changes only while `sclk` is low. It is stable on the cycle `sclk` rises and throughout the high phase.
- R4: When `msbFirst` is 0, each field is sent from its bit 0 upward. When it is 1, each field is sent from its top counted bit downward.
- R5: The width code for slot k sits in `fieldBits[5k+4:5k]`. Code 0 means 8 bits, codes 1 to 16 mean that many bits, and codes 17 to 31 mean 16 bits. Only bits `[N-1:0]` of the field are sent. For example, the value 250 with code 4 in highest-first order gives 1,0,1,0.
- R6: The field for slot k sits in `fieldData[16k+15:16k]`. Slots 0 up to count-1 are sent in that order with no extra gap. The number of clock pulses equals the sum of the field widths. For example, 250 with code 4 followed by 1045 with code 16 gives the 20-bit stream A0415 (hex).
- R7: A field count of 0 gives one busy cycle, then `done`, with no clock pulse and no change on `sdo`. A count above 4 is treated as 4.
- R8: The setup, high and hold phases last `setupTicks`, `highTicks` and `holdTicks` cycles, and a value of 0 counts as 1. A transfer of B bits keeps `busy` high for 1 + B·(setup+high+hold) cycles.
- R9: `done` is high for exactly one cycle, and `busy` is low in that cycle. After the last pulse, `sclk` stays low and `sdo` keeps the last bit sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse, honoured only when idle |
| msbFirst | input | 1 | 0: lowest bit first, 1: highest bit first |
| fieldCount | input | 3 | Number of fields to send (0 to 4, larger clamps to 4) |
| fieldData | input | 64 | Four 16-bit field values, slot 0 in the low bits |
| fieldBits | input | 20 | Four 5-bit width codes, slot 0 in the low bits |
| setupTicks | input | 8 | Cycles data is held before the rising clock |
| highTicks | input | 8 | Cycles the clock stays high |
| holdTicks | input | 8 | Cycles the clock stays low after falling |
| sdo | output | 1 | Serial data output |
| sclk | output | 1 | Serial clock output |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Each kind of internal fault shows up at the ports within a predictable time:

- A wrong field index or bit counter makes a wrong bit appear on `sdo`. This shows at the very next rising `sclk`. It also changes the number of pulses before `done`.
- A wrong phase timer stretches or shortens a high or low run. This is visible within one bit period.
- A stale final-bit flag moves the `done` pulse, so the busy length no longer equals 1 + B·period.
- A start accepted while busy changes the captured order or count. This shows in the same transfer as a corrupted stream, or as a second busy period right after `done`.

// File: rtl/sst_pkg.sv
package sst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETUP,
    ST_HIGH,
    ST_HOLD
  } sstState_e;

  typedef struct packed {
    logic load;
    logic present;
    logic advance;
  } sstStrobe_t;

endpackage

// File: rtl/sst_datapath.sv
module sst_datapath
  import sst_pkg::*;
#(
  parameter int MAX_FIELDS   = 4,
  parameter int FIELD_W      = 16,
  parameter int WCODE_W      = 5,
  parameter int DEFAULT_BITS = 8,
  localparam int IDX_W = $clog2(MAX_FIELDS + 1),
  localparam int SEL_W = (MAX_FIELDS > 1) ? $clog2(MAX_FIELDS) : 1,
  localparam int BIT_W = $clog2(FIELD_W + 1),
  localparam int POS_W = (FIELD_W > 1) ? $clog2(FIELD_W) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  sstStrobe_t                    strobe,
  input  logic                          msbFirstIn,
  input  logic [IDX_W-1:0]              fieldCountIn,
  input  logic [MAX_FIELDS*FIELD_W-1:0] fieldDataIn,
  input  logic [MAX_FIELDS*WCODE_W-1:0] fieldBitsIn,
  output logic                          sdo,
  output logic                          lastBit,
  output logic                          noFields
);

  logic [FIELD_W-1:0] dataReg  [MAX_FIELDS];
  logic [BIT_W-1:0]   widthReg [MAX_FIELDS];
  logic [BIT_W-1:0]   widthDec [MAX_FIELDS];
  logic [IDX_W-1:0]   countReg;
  logic [IDX_W-1:0]   countClamped;
  logic               modeReg;
  logic [IDX_W-1:0]   fieldIdx;
  logic [BIT_W-1:0]   bitCnt;

  // width code decode, one per slot
  for (genvar g = 0; g < MAX_FIELDS; g++) begin : gWidth
    logic [WCODE_W-1:0] code;
    assign code = fieldBitsIn[g*WCODE_W +: WCODE_W];
    always_comb begin
      if (code == '0)
        widthDec[g] = BIT_W'(DEFAULT_BITS);
      else if (int'(code) > FIELD_W)
        widthDec[g] = BIT_W'(FIELD_W);
      else
        widthDec[g] = BIT_W'(code);
    end
  end

  assign countClamped = (int'(fieldCountIn) > MAX_FIELDS) ? IDX_W'(MAX_FIELDS) : fieldCountIn;

  // current field selection
  logic [SEL_W-1:0]   selIdx;
  logic [BIT_W-1:0]   curWidth;
  logic [FIELD_W-1:0] curData;
  logic [BIT_W-1:0]   pos;
  logic               curBit;
  logic               lastInField;

  assign selIdx   = (int'(fieldIdx) < MAX_FIELDS) ? SEL_W'(fieldIdx) : '0;
  assign curWidth = widthReg[selIdx];
  assign curData  = dataReg[selIdx];
  assign pos      = modeReg ? (curWidth - BIT_W'(1) - bitCnt) : bitCnt;
  assign curBit   = curData[POS_W'(pos)];

  assign lastInField = (bitCnt == curWidth - BIT_W'(1));
  assign lastBit     = lastInField && ((fieldIdx + IDX_W'(1)) == countReg);
  assign noFields    = (countReg == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countReg <= '0;
      modeReg  <= 1'b0;
      fieldIdx <= '0;
      bitCnt   <= '0;
      sdo      <= 1'b0;
      for (int i = 0; i < MAX_FIELDS; i++) begin
        dataReg[i]  <= '0;
        widthReg[i] <= BIT_W'(DEFAULT_BITS);
      end
    end else begin
      if (strobe.load) begin
        countReg <= countClamped;
        modeReg  <= msbFirstIn;
        fieldIdx <= '0;
        bitCnt   <= '0;
        for (int i = 0; i < MAX_FIELDS; i++) begin
          dataReg[i]  <= fieldDataIn[i*FIELD_W +: FIELD_W];
          widthReg[i] <= widthDec[i];
        end
      end else if (strobe.advance) begin
        if (lastInField) begin
          fieldIdx <= fieldIdx + IDX_W'(1);
          bitCnt   <= '0;
        end else begin
          bitCnt <= bitCnt + BIT_W'(1);
        end
      end
      if (strobe.present)
        sdo <= curBit;
    end
  end

  // R6: a bit is only presented from a slot inside the captured count
  a_r6_present_in_list: assert property (@(posedge clk) disable iff (!rstN)
    strobe.present |-> (fieldIdx < countReg));

  // R5: the bit counter never runs past the width of its field
  a_r5_bit_in_width: assert property (@(posedge clk) disable iff (!rstN)
    (fieldIdx < countReg) |-> (bitCnt < curWidth));

  // R7: captured count is clamped to the slot count
  a_r7_count_clamped: assert property (@(posedge clk) disable iff (!rstN)
    int'(countReg) <= MAX_FIELDS);

endmodule

// File: rtl/sst_ctrl.sv
module sst_ctrl
  import sst_pkg::*;
#(
  parameter int TIMER_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startReq,
  input  logic [TIMER_W-1:0] setupTicks,
  input  logic [TIMER_W-1:0] highTicks,
  input  logic [TIMER_W-1:0] holdTicks,
  input  logic               lastBit,
  input  logic               noFields,
  output sstStrobe_t         strobe,
  output logic               sclk,
  output logic               busy,
  output logic               done
);

  sstState_e          state;
  logic [TIMER_W-1:0] timer;
  logic [TIMER_W-1:0] setupReg;
  logic [TIMER_W-1:0] highReg;
  logic [TIMER_W-1:0] holdReg;
  logic               finalFlag;

  function automatic logic [TIMER_W-1:0] loadVal(input logic [TIMER_W-1:0] t);
    return (t == '0) ? '0 : t - TIMER_W'(1);
  endfunction

  always_comb begin
    strobe.load    = (state == ST_IDLE) && startReq;
    strobe.present = ((state == ST_LOAD) && !noFields) ||
                     ((state == ST_HOLD) && (timer == '0) && !finalFlag);
    strobe.advance = (state == ST_HIGH) && (timer == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      timer     <= '0;
      setupReg  <= '0;
      highReg   <= '0;
      holdReg   <= '0;
      finalFlag <= 1'b0;
      sclk      <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startReq) begin
            setupReg  <= setupTicks;
            highReg   <= highTicks;
            holdReg   <= holdTicks;
            finalFlag <= 1'b0;
            busy      <= 1'b1;
            state     <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (noFields) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            timer <= loadVal(setupReg);
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (timer == '0) begin
            sclk  <= 1'b1;
            timer <= loadVal(highReg);
            state <= ST_HIGH;
          end else begin
            timer <= timer - TIMER_W'(1);
          end
        end
        ST_HIGH: begin
          if (timer == '0) begin
            sclk      <= 1'b0;
            finalFlag <= lastBit;
            timer     <= loadVal(holdReg);
            state     <= ST_HOLD;
          end else begin
            timer <= timer - TIMER_W'(1);
          end
        end
        ST_HOLD: begin
          if (timer == '0) begin
            if (finalFlag) begin
              busy  <= 1'b0;
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              timer <= loadVal(setupReg);
              state <= ST_SETUP;
            end
          end else begin
            timer <= timer - TIMER_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: clock stays low through the capture cycle
  a_r2_load_clock_low: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD) |-> !sclk);

  // R2: idle means clock low
  a_r2_idle_clock_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk);

  // R1: busy only ends together with done
  a_r1_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R9: done is a single-cycle pulse while not busy
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy ##1 !done));

  // R1: a start while busy does not reload the phase settings
  a_r1_settings_held: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(setupReg) && $stable(highReg) && $stable(holdReg)));

endmodule

// File: rtl/sync_shift_tx.sv
module sync_shift_tx
  import sst_pkg::*;
#(
  parameter int MAX_FIELDS   = 4,
  parameter int FIELD_W      = 16,
  parameter int WCODE_W      = 5,
  parameter int DEFAULT_BITS = 8,
  parameter int TIMER_W      = 8,
  localparam int IDX_W = $clog2(MAX_FIELDS + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          startReq,
  input  logic                          msbFirst,
  input  logic [IDX_W-1:0]              fieldCount,
  input  logic [MAX_FIELDS*FIELD_W-1:0] fieldData,
  input  logic [MAX_FIELDS*WCODE_W-1:0] fieldBits,
  input  logic [TIMER_W-1:0]            setupTicks,
  input  logic [TIMER_W-1:0]            highTicks,
  input  logic [TIMER_W-1:0]            holdTicks,
  output logic                          sdo,
  output logic                          sclk,
  output logic                          busy,
  output logic                          done
);

  sstStrobe_t strobe;
  logic       lastBit;
  logic       noFields;

  sst_ctrl #(
    .TIMER_W (TIMER_W)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .setupTicks (setupTicks),
    .highTicks  (highTicks),
    .holdTicks  (holdTicks),
    .lastBit    (lastBit),
    .noFields   (noFields),
    .strobe     (strobe),
    .sclk       (sclk),
    .busy       (busy),
    .done       (done)
  );

  sst_datapath #(
    .MAX_FIELDS   (MAX_FIELDS),
    .FIELD_W      (FIELD_W),
    .WCODE_W      (WCODE_W),
    .DEFAULT_BITS (DEFAULT_BITS)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .msbFirstIn   (msbFirst),
    .fieldCountIn (fieldCount),
    .fieldDataIn  (fieldData),
    .fieldBitsIn  (fieldBits),
    .sdo          (sdo),
    .lastBit      (lastBit),
    .noFields     (noFields)
  );

  // R3: data is stable across the whole high phase
  a_r3_stable_while_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(sdo));

  // R3: data settled before the clock rises
  a_r3_setup_at_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> $stable(sdo));

endmodule

// File: tb/sim_sync_shift_tx.sv
`timescale 1ns/1ps
module sim_sync_shift_tx;

  logic        clk = 1'b0;
  logic        rstN;
  logic        startReq;
  logic        msbFirst;
  logic [2:0]  fieldCount;
  logic [63:0] fieldData;
  logic [19:0] fieldBits;
  logic [7:0]  setupTicks, highTicks, holdTicks;
  logic        sdo, sclk, busy, done;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  sync_shift_tx u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq), .msbFirst(msbFirst),
    .fieldCount(fieldCount), .fieldData(fieldData), .fieldBits(fieldBits),
    .setupTicks(setupTicks), .highTicks(highTicks), .holdTicks(holdTicks),
    .sdo(sdo), .sclk(sclk), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  logic [63:0] gotStream;
  int          gotBits;

  // one transfer; poke = issue a conflicting start mid-run (R1)
  task automatic runXfer(input logic mode, input int cnt, input logic [63:0] data,
                         input logic [19:0] codes, input int s, input int h, input int l,
                         input bit poke);
    logic [63:0] exp = '0;
    int nExp = 0;
    int effCnt = (cnt > 4) ? 4 : cnt;
    int se = (s == 0) ? 1 : s;
    int he = (h == 0) ? 1 : h;
    int le = (l == 0) ? 1 : l;
    int busyCycles = 0, lowRun = 0, highRun = 0, guard = 0;
    int timingBad = 0;
    bit prev = 0, doneSeen = 0, busyAtDone = 0;
    logic sdoBefore, sdoAtRise;
    for (int f = 0; f < effCnt; f++) begin
      int code = int'(codes[5*f +: 5]);
      int w = (code == 0) ? 8 : ((code > 16) ? 16 : code);
      for (int i = 0; i < w; i++) begin
        int p = mode ? (w - 1 - i) : i;
        exp[nExp] = data[16*f + p];
        nExp++;
      end
    end
    gotStream = '0;
    gotBits = 0;
    sdoAtRise = 1'b0;
    msbFirst = mode; fieldCount = 3'(cnt); fieldData = data; fieldBits = codes;
    setupTicks = 8'(s); highTicks = 8'(h); holdTicks = 8'(l);
    sdoBefore = sdo;
    startReq = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startReq = 1'b0;
    // R2: capture cycle keeps clock low and data unchanged
    chk(!sclk && (sdo == sdoBefore) && busy, "R2 capture cycle", {sclk, sdo, busy}, {1'b0, sdoBefore, 1'b1});
    while (!doneSeen && guard < 20000) begin
      guard++;
      if (poke && busyCycles == 5) begin
        startReq = 1'b1; fieldCount = 3'd1; msbFirst = ~mode; setupTicks = 8'd7;
      end else begin
        startReq = 1'b0;
      end
      if (done) begin
        doneSeen = 1;
        busyAtDone = busy;
      end else if (busy) begin
        busyCycles++;
        if (sclk) begin
          if (!prev) begin
            if (lowRun != ((gotBits == 0) ? 1 + se : le + se)) timingBad++;
            lowRun = 0;
            sdoAtRise = sdo;
            if (gotBits < 64) gotStream[gotBits] = sdo;
            gotBits++;
          end else if (sdo != sdoAtRise) begin
            timingBad++;
          end
          highRun++;
        end else begin
          if (prev) begin
            if (highRun != he) timingBad++;
            highRun = 0;
          end
          lowRun++;
        end
        prev = sclk;
      end
      if (!doneSeen) @(negedge clk);
    end
    startReq = 1'b0;
    chk(doneSeen && !busyAtDone, "R9 done with busy low", {doneSeen, busyAtDone}, 2'b10);
    chk(gotBits == nExp, "R6 pulse count", gotBits, nExp);
    chk(gotStream == exp, "R4 R5 R6 bit stream", gotStream, exp);
    chk(timingBad == 0, "R3 R8 phase lengths", timingBad, 0);
    chk(busyCycles == 1 + nExp * (se + he + le), "R8 R1 busy length", busyCycles,
        1 + nExp * (se + he + le));
    @(negedge clk);
    chk(!done && !busy && !sclk, "R9 R1 single done, idle after", {done, busy, sclk}, 3'b000);
    if (nExp > 0)
      chk(sdo == exp[nExp-1], "R9 data holds last bit", sdo, exp[nExp-1]);
    else
      chk(sdo == sdoBefore, "R7 empty list leaves data", sdo, sdoBefore);
  endtask

  initial begin
    rstN = 1'b0; startReq = 1'b0; msbFirst = 1'b0; fieldCount = '0;
    fieldData = '0; fieldBits = '0; setupTicks = 8'd1; highTicks = 8'd1; holdTicks = 8'd1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!sclk, "R2 reset clock low", sclk, 0);
    chk(!sdo, "R9 reset data low", sdo, 0);
    chk(!busy, "R1 reset idle", busy, 0);
    chk(!done, "R9 reset no done", done, 0);

    // R5 example: 250 with 4 bits, highest first -> 1010
    runXfer(1'b1, 1, 64'd250, 20'd4, 1, 1, 1, 1'b0);
    chk({gotStream[0], gotStream[1], gotStream[2], gotStream[3]} == 4'b1010,
        "R5 low four bits of 250", {gotStream[0], gotStream[1], gotStream[2], gotStream[3]}, 4'b1010);

    // R6 example: 4 bits of 250 then 16 bits of 1045 -> 20'hA0415
    runXfer(1'b1, 2, {32'd0, 16'd1045, 16'd250}, {10'd0, 5'd16, 5'd4}, 1, 1, 1, 1'b0);
    begin
      logic [19:0] v = '0;
      for (int i = 0; i < 20; i++) v = {v[18:0], gotStream[i]};
      chk(v == 20'hA0415, "R6 chained 20-bit stream", v, 20'hA0415);
    end

    // R4 R5: every width code, both orders, two patterns
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 21; c++)
        for (int p = 0; p < 2; p++)
          runXfer(m[0], 1, {48'h5A5A_C3C3_9999, (p != 0) ? 16'hA5C3 : 16'h1F6B},
                  {15'h3FFF, 5'(c)}, 1, 1, 1, 1'b0);

    // R6 R7: every field count including 0 and clamped values
    for (int m = 0; m < 2; m++)
      for (int n = 0; n < 8; n++)
        runXfer(m[0], n, 64'h0123_4567_89AB_CDEF, {5'd1, 5'd16, 5'd0, 5'd3}, 1, 2, 1, 1'b0);

    // R8: phase length sweep including zero settings
    for (int s = 0; s < 4; s++)
      for (int h = 0; h < 4; h++)
        for (int l = 0; l < 4; l++)
          runXfer(s[0] ^ h[0], 2, 64'h0000_0000_0006_0005, {10'd0, 5'd3, 5'd2}, s, h, l, 1'b0);

    // R1: start while busy is ignored
    runXfer(1'b0, 3, 64'h0000_BEEF_1234_00F0, {5'd0, 5'd12, 5'd5, 5'd9}, 2, 1, 2, 1'b1);
    repeat (3) begin
      @(negedge clk);
      chk(!busy && !sclk, "R1 no queued start", {busy, sclk}, 2'b00);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule